// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit block under a 128-bit cipher key. It has one round datapath, and a seven-state sequencer steps that datapath through the cipher. A start strobe in the idle state captures the plaintext and the key. The core then spends ten cycles expanding the key, and stores round keys 0 to 10 in an internal buffer.

After the key expansion, the rounds run one transformation per clock:
- one cycle for the whitening key addition;
- three cycles for each of rounds 1 to 9 (substitute-and-shift, column mixing, key addition);
- two cycles for round 10 (substitute-and-shift, final key addition).

Each transformation writes its own holding register. When the block is complete, the ciphertext is registered and a one-cycle done pulse follows. The host may start the next block on the cycle after done falls.

Top module: `aes_iter_enc`

## Requirements
- R1: During and right after synchronous reset, done_o is 0 and cipher_o is all zeros.
- R2: The rising edge on which start_i is sampled high in the idle state captures plain_i and key_i. Later changes on those inputs do not affect the block in progress.
- R3: cipher_o is the AES-128 encryption of the captured plaintext under the captured key. Byte 0 of each 128-bit value sits in bits 127:120, and the bytes fill the state column by column.
- R4: Key expansion takes ten cycles. The round phase then takes 30 cycles in this order: one key addition, nine rounds of substitute-and-shift, mix and add, and a last round with substitute-and-shift and a final add only.
- R5: done_o first reads high after the 40th rising edge that follows the edge accepting start_i.
- R6: done_o stays high for exactly one cycle.
- R7: cipher_o holds its value in every cycle where done_o is low, so it stays stable until the next block completes.
- R8: A start_i pulse is ignored while a block is in progress, and also in the cycle where done_o is high.
- R9: A start_i pulse in the first cycle after done_o falls is accepted and yields a correct result with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new block when idle |
| plain_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| cipher_o | output | 128 | Ciphertext, held until the next block completes |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The core is run on three known-answer pairs:
- **Ascending bytes.** Plaintext 00112233…ff under key 000102…0f.
- **Irregular bytes.** A second pair whose bytes vary irregularly.
- **All zeros.** Plaintext and key both zero. This pair exposes S-box mistakes at input zero and in the affine constant, which patterned bytes can mask.

Between them the three pairs tell apart:
- byte-order errors;
- row-shift direction errors;
- key-schedule rotation and round-constant errors;
- a round 10 that wrongly mixes columns.

The inputs are scrambled right after start. This separates a core that captures its operands from one that reads them live. Stray start pulses are issued both mid-run and in the done cycle, together with a back-to-back start. These separate the ignore rule from the acceptance rule, and the bench counts the exact number of cycles from start to done in each run.

// File: rtl/aes_iter_enc.sv
module aes_iter_enc (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [127:0] plain_i,
  input  logic [127:0] key_i,
  output logic [127:0] cipher_o,
  output logic         done_o
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_KEY  = 3'd1;
  localparam logic [2:0] S_ARK  = 3'd2;
  localparam logic [2:0] S_SS   = 3'd3;
  localparam logic [2:0] S_MIX  = 3'd4;
  localparam logic [2:0] S_FIN  = 3'd5;
  localparam logic [2:0] S_DONE = 3'd6;
  localparam int         NRK    = 10;

  logic [2:0]   st;
  logic [3:0]   rnd, kcnt;
  logic [127:0] rk [0:NRK];
  logic [127:0] pt_q, ark_q, ss_q, mc_q, ct_q;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p, r, q;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    q = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]};
    return q ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] i);
    case (i)
      4'd0: return 8'h01;
      4'd1: return 8'h02;
      4'd2: return 8'h04;
      4'd3: return 8'h08;
      4'd4: return 8'h10;
      4'd5: return 8'h20;
      4'd6: return 8'h40;
      4'd7: return 8'h80;
      4'd8: return 8'h1b;
      4'd9: return 8'h36;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [127:0] kexp(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] t, n0, n1, n2, n3;
    t  = {sbox(k[23:16]), sbox(k[15:8]), sbox(k[7:0]), sbox(k[31:24])} ^ {rc, 24'h0};
    n0 = k[127:96] ^ t;
    n1 = k[95:64]  ^ n0;
    n2 = k[63:32]  ^ n1;
    n3 = k[31:0]   ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  // byte i = column*4 + row, byte 0 in the top bits
  function automatic logic [127:0] subshift(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8*(4*c + r) -: 8] = sbox(s[127 - 8*(4*((c + r) % 4) + r) -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] mix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    o = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127 - 32*c -: 8];
      a1 = s[119 - 32*c -: 8];
      a2 = s[111 - 32*c -: 8];
      a3 = s[103 - 32*c -: 8];
      o[127 - 32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[119 - 32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[111 - 32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[103 - 32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      rnd   <= '0;
      kcnt  <= '0;
      pt_q  <= '0;
      ark_q <= '0;
      ss_q  <= '0;
      mc_q  <= '0;
      ct_q  <= '0;
      for (int i = 0; i <= NRK; i++) rk[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          pt_q  <= plain_i;
          rk[0] <= key_i;
          kcnt  <= '0;
          st    <= S_KEY;
        end
        S_KEY: begin
          rk[4'(kcnt + 4'd1)] <= kexp(rk[kcnt], rcon(kcnt));
          kcnt <= kcnt + 4'd1;
          if (kcnt == 4'(NRK - 1)) begin
            rnd <= '0;
            st  <= S_ARK;
          end
        end
        S_ARK: begin
          ark_q <= ((rnd == 4'd0) ? pt_q : mc_q) ^ rk[rnd];
          rnd   <= rnd + 4'd1;
          st    <= S_SS;
        end
        S_SS: begin
          ss_q <= subshift(ark_q);
          st   <= (rnd == 4'(NRK)) ? S_FIN : S_MIX;
        end
        S_MIX: begin
          mc_q <= mix(ss_q);
          st   <= S_ARK;
        end
        S_FIN: begin
          ct_q <= ss_q ^ rk[NRK];
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cipher_o = ct_q;
  assign done_o   = (st == S_DONE);
endmodule

// File: rtl/aes_iter_enc_chk.sv
module aes_iter_enc_chk (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         done_o,
  input logic [127:0] cipher_o,
  input logic [2:0]   st,
  input logic [3:0]   rnd,
  input logic [3:0]   kcnt
);
  logic       run;
  logic [6:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (st == 3'd0 && start_i) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done_o) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 7'd1;
    end
  end

  p_key_to_round_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd1 && kcnt == 4'd9) |=> (st == 3'd2 && rnd == 4'd0));
  p_last_skips_mix_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3 && rnd == 4'd10) |=> (st == 3'd5));
  p_mid_mixes_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3 && rnd != 4'd10) |=> (st == 3'd4));
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run && cnt == 7'd40));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(cipher_o));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st != 3'd0 && st != 3'd6) |=> (st != 3'd0));
endmodule

bind aes_iter_enc aes_iter_enc_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .cipher_o(cipher_o), .st(st), .rnd(rnd), .kcnt(kcnt)
);

// File: tb/aes_iter_enc_tb.sv
module aes_iter_enc_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [127:0] plain_i = '0;
  logic [127:0] key_i = '0;
  logic [127:0] cipher_o;
  logic         done_o;
  int checks = 0;
  int fails = 0;

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  always #10 clk = ~clk;

  aes_iter_enc u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .plain_i(plain_i),
    .key_i(key_i), .cipher_o(cipher_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; inj=1 issues a stray start mid-run
  task automatic run_block(input logic [127:0] p, input logic [127:0] k,
                           input logic [127:0] c, input bit inj, input string req);
    int cyc;
    logic [127:0] held;
    plain_i = p;
    key_i   = k;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    plain_i = ~p;
    key_i   = ~k;
    cyc = 0;
    while (!done_o && cyc < 100) begin
      if (inj && cyc == 5) start_i = 1'b1; else start_i = 1'b0;
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(cyc == 40, {req, " R5 R4 latency"}, 128'(cyc), 128'd40);
    chk(cipher_o == c, {req, " R3 R2 ciphertext"}, cipher_o, c);
    held = cipher_o;
    @(negedge clk);
    chk(!done_o, {req, " R6 done one cycle"}, 128'(done_o), 128'd0);
    chk(cipher_o == held, {req, " R7 hold"}, cipher_o, held);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done_o, "R1 done in reset", 128'(done_o), 128'd0);
    chk(cipher_o == '0, "R1 cipher in reset", cipher_o, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && cipher_o == '0, "R1 after reset", cipher_o, 128'd0);
  endtask

  task automatic t_start_in_done;
    logic [127:0] held;
    bit seen;
    plain_i = P2; key_i = K2; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(cipher_o == C2, "R8 setup ciphertext", cipher_o, C2);
    held = cipher_o;
    plain_i = '0; key_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
    chk(!seen, "R8 start during done ignored", 128'(seen), 128'd0);
    chk(cipher_o == held, "R8 R7 output kept", cipher_o, held);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_block(P1, K1, C1, 1'b0, "ascending");
    run_block(P2, K2, C2, 1'b0, "R9 back-to-back");
    run_block('0, '0, C0, 1'b0, "zero");
    run_block(P1, K1, C1, 1'b1, "R8 stray start mid-run");
    t_start_in_done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule